// File: doc/BRIEF.md
# Edge/Level Interrupt Request Latch

This block turns eight raw interrupt request inputs into a registered vector of pending requests. A trigger-mode register chooses, per line, whether the pending bit is latched on a rising edge or simply follows the input level. Every line in edge mode keeps its pending bit until it is acknowledged, poll-cleared or wiped by an initialization command. A level-mode line tracks its input and ignores acknowledges.

The trigger-mode register is written through a small port. The written value is ANDed with a writable-bit mask fixed per instance by a parameter, so some lines can never leave edge mode. The default mask is 8'hF8, which pins lines 0 to 2 to edge mode; a second instance would typically use 8'hDE. Priority resolution and any processor-facing logic sit outside this block and consume `pend_o` and `trig_o`.

Top module: `irq_req_latch`

## Requirements
- R1: While `rst` is high at a clock edge, `pend_o` and `trig_o` become all zero; the edge history also clears, so an input already high when reset drops is seen as a new rising edge.
- R2: A line whose `trig_o` bit is 1 (level mode) has its `pend_o` bit equal, after each edge, to the value its `req_in` bit had at that edge.
- R3: A line whose `trig_o` bit is 0 (edge mode) sets its `pend_o` bit at the edge where `req_in` is sampled 1 after having been sampled 0 at the previous edge.
- R4: In edge mode a fall of the input does not clear the pending bit; the bit stays set until a clear source reaches it.
- R5: When `ack_valid` is 1, the pending bit of line `ack_idx` clears at the next edge if that line is in edge mode.
- R6: An acknowledge addressed to a level-mode line has no effect on that line's pending bit, which keeps following its input.
- R7: When `trig_wr_en` is 1 and `init_clr` is 0, `trig_o` becomes `trig_wr_data & TRIG_WMASK` at the next edge; bits outside the mask always read 0.
- R8: When `poll_clr` is 1, the pending bit of line `poll_idx` clears at the next edge if the line is in edge mode; a level-mode line keeps following its input.
- R9: When `init_clr` is 1, at the next edge every pending bit clears and `trig_o` becomes 0 (init wins over a simultaneous mode write); the edge history is kept, so an input held high does not set a bit again afterwards.
- R10: A rising edge detected in the same cycle as an acknowledge, poll clear or init of that line sets the bit: set takes precedence over clear.
- R11: With neither `trig_wr_en` nor `init_clr` asserted, `trig_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_in | input | NUM_LINES | Raw request levels, sampled at each rising clock edge |
| trig_wr_en | input | 1 | Write strobe for the trigger-mode register |
| trig_wr_data | input | NUM_LINES | Mode value to write, 1 = level, 0 = edge |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_idx | input | IDX_W | Line being acknowledged |
| poll_clr | input | 1 | Poll-read clear strobe |
| poll_idx | input | IDX_W | Line cleared by the poll read |
| init_clr | input | 1 | Initialization: clear requests and trigger modes |
| pend_o | output | NUM_LINES | Registered pending request vector |
| trig_o | output | NUM_LINES | Registered trigger-mode register value |

## Verification
Every result of this block is due exactly one clock edge after the stimulus that causes it: a request level, rising edge, acknowledge, poll clear, init or mode write applied before edge k is visible on `pend_o` or `trig_o` after edge k. The bench drives inputs on the falling edge, advances a reference model by one step for the same rising edge, and compares both outputs on the following falling edge, so each check samples exactly one register stage after its cause. Directed sequences cover the held-high, simultaneous set/clear and init cases, and a seeded random run mixes all sources.

// File: rtl/irq_latch_pkg.sv
package irq_latch_pkg;

  // Clear sources that act on the pending vector in one cycle.
  typedef struct packed {
    logic init;
    logic ack;
    logic poll;
  } clr_ctl_t;

  localparam logic [7:0] DEFAULT_TRIG_WMASK = 8'hF8;

endpackage

// File: rtl/irq_sample_edge.sv
module irq_sample_edge #(
  parameter int unsigned NUM_LINES = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] req_i,
  output logic [NUM_LINES-1:0] rise_o
);

  logic [NUM_LINES-1:0] hist_q;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) hist_q[g] <= 1'b0;
      else     hist_q[g] <= req_i[g];
    end

    assign rise_o[g] = req_i[g] & ~hist_q[g];

    // R3: a rise is a single-cycle event; the history catches up next cycle
    a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
      rise_o[g] |=> !rise_o[g]);
  end

endmodule

// File: rtl/irq_mode_reg.sv
module irq_mode_reg #(
  parameter int unsigned          NUM_LINES  = 8,
  parameter logic [NUM_LINES-1:0] TRIG_WMASK = NUM_LINES'(8'hF8)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 init_i,
  input  logic                 wr_en_i,
  input  logic [NUM_LINES-1:0] wr_data_i,
  output logic [NUM_LINES-1:0] trig_o
);

  logic [NUM_LINES-1:0] trig_q;

  always_ff @(posedge clk) begin
    if (rst || init_i)  trig_q <= '0;
    else if (wr_en_i)   trig_q <= wr_data_i & TRIG_WMASK;
  end

  assign trig_o = trig_q;

  a_r9_init_mode: assert property (@(posedge clk) disable iff (rst)
    init_i |=> (trig_q == '0));

  a_r11_mode_hold: assert property (@(posedge clk) disable iff (rst)
    (!init_i && !wr_en_i) |=> $stable(trig_q));

  a_r7_pinned_edge: assert property (@(posedge clk) disable iff (rst)
    wr_en_i |=> ((trig_q & ~TRIG_WMASK) == '0));

endmodule

// File: rtl/irq_clear_dec.sv
module irq_clear_dec
  import irq_latch_pkg::*;
#(
  parameter int unsigned NUM_LINES = 8,
  localparam int unsigned IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  clr_ctl_t             ctl_i,
  input  logic [IDX_W-1:0]     ack_idx_i,
  input  logic [IDX_W-1:0]     poll_idx_i,
  input  logic [NUM_LINES-1:0] trig_i,
  output logic [NUM_LINES-1:0] clr_o
);

  logic [NUM_LINES-1:0] ack_hit;
  logic [NUM_LINES-1:0] poll_hit;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_dec
    assign ack_hit[g]  = ctl_i.ack  && (ack_idx_i  == IDX_W'(g));
    assign poll_hit[g] = ctl_i.poll && (poll_idx_i == IDX_W'(g));
  end

  // Only edge-mode lines hold state worth clearing; level lines follow input.
  assign clr_o = ((ack_hit | poll_hit) & ~trig_i) | {NUM_LINES{ctl_i.init}};

endmodule

// File: rtl/irq_pend_bits.sv
module irq_pend_bits #(
  parameter int unsigned NUM_LINES = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 init_i,
  input  logic [NUM_LINES-1:0] req_i,
  input  logic [NUM_LINES-1:0] rise_i,
  input  logic [NUM_LINES-1:0] trig_i,
  input  logic [NUM_LINES-1:0] clr_i,
  output logic [NUM_LINES-1:0] pend_o
);

  logic [NUM_LINES-1:0] pend_q;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)            pend_q[g] <= 1'b0;
      else if (init_i)    pend_q[g] <= rise_i[g];
      else if (trig_i[g]) pend_q[g] <= req_i[g];
      else                pend_q[g] <= (pend_q[g] & ~clr_i[g]) | rise_i[g];
    end

    a_r2_level_follow: assert property (@(posedge clk) disable iff (rst)
      (!init_i && trig_i[g]) |=> (pend_o[g] == $past(req_i[g])));

    a_r4_edge_hold: assert property (@(posedge clk) disable iff (rst)
      (!init_i && !trig_i[g] && pend_o[g] && !clr_i[g]) |=> pend_o[g]);

    a_r10_set_wins: assert property (@(posedge clk) disable iff (rst)
      rise_i[g] |=> pend_o[g]);
  end

  assign pend_o = pend_q;

endmodule

// File: rtl/irq_req_latch.sv
module irq_req_latch
  import irq_latch_pkg::*;
#(
  parameter int unsigned          NUM_LINES  = 8,
  parameter logic [NUM_LINES-1:0] TRIG_WMASK = NUM_LINES'(DEFAULT_TRIG_WMASK),
  localparam int unsigned IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] req_in,
  input  logic                 trig_wr_en,
  input  logic [NUM_LINES-1:0] trig_wr_data,
  input  logic                 ack_valid,
  input  logic [IDX_W-1:0]     ack_idx,
  input  logic                 poll_clr,
  input  logic [IDX_W-1:0]     poll_idx,
  input  logic                 init_clr,
  output logic [NUM_LINES-1:0] pend_o,
  output logic [NUM_LINES-1:0] trig_o
);

  logic [NUM_LINES-1:0] rise;
  logic [NUM_LINES-1:0] clr_vec;
  clr_ctl_t             ctl;

  assign ctl.init = init_clr;
  assign ctl.ack  = ack_valid;
  assign ctl.poll = poll_clr;

  irq_sample_edge #(.NUM_LINES(NUM_LINES)) u_edge (
    .clk    (clk),
    .rst    (rst),
    .req_i  (req_in),
    .rise_o (rise)
  );

  irq_mode_reg #(.NUM_LINES(NUM_LINES), .TRIG_WMASK(TRIG_WMASK)) u_mode (
    .clk       (clk),
    .rst       (rst),
    .init_i    (init_clr),
    .wr_en_i   (trig_wr_en),
    .wr_data_i (trig_wr_data),
    .trig_o    (trig_o)
  );

  irq_clear_dec #(.NUM_LINES(NUM_LINES)) u_clr (
    .ctl_i      (ctl),
    .ack_idx_i  (ack_idx),
    .poll_idx_i (poll_idx),
    .trig_i     (trig_o),
    .clr_o      (clr_vec)
  );

  irq_pend_bits #(.NUM_LINES(NUM_LINES)) u_pend (
    .clk    (clk),
    .rst    (rst),
    .init_i (init_clr),
    .req_i  (req_in),
    .rise_i (rise),
    .trig_i (trig_o),
    .clr_i  (clr_vec),
    .pend_o (pend_o)
  );

  // R1: reset empties both registers
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (pend_o == '0 && trig_o == '0));

  // R5: acknowledged edge-mode line without a new edge is cleared
  a_r5_ack_clears: assert property (@(posedge clk) disable iff (rst)
    (ack_valid && (32'(ack_idx) < NUM_LINES) && !trig_o[ack_idx] && !rise[ack_idx])
      |=> !pend_o[$past(ack_idx)]);

  // R9: init without any edge leaves nothing pending
  a_r9_init_empty: assert property (@(posedge clk) disable iff (rst)
    (init_clr && rise == '0) |=> (pend_o == '0));

endmodule

// File: tb/irq_req_latch_tb.sv
`timescale 1ns/1ps
module irq_req_latch_tb;

  localparam int N = 8;
  localparam logic [7:0] MASK = 8'hF8;

  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] req_in;
  logic       trig_wr_en;
  logic [7:0] trig_wr_data;
  logic       ack_valid;
  logic [2:0] ack_idx;
  logic       poll_clr;
  logic [2:0] poll_idx;
  logic       init_clr;
  logic [7:0] pend_o;
  logic [7:0] trig_o;

  int checks = 0;
  int errors = 0;

  // reference model state
  logic [7:0] m_hist, m_pend, m_trig;

  always #5 clk = ~clk;

  irq_req_latch u_dut (
    .clk(clk), .rst(rst), .req_in(req_in),
    .trig_wr_en(trig_wr_en), .trig_wr_data(trig_wr_data),
    .ack_valid(ack_valid), .ack_idx(ack_idx),
    .poll_clr(poll_clr), .poll_idx(poll_idx),
    .init_clr(init_clr), .pend_o(pend_o), .trig_o(trig_o)
  );

  function automatic logic [7:0] next_pend();
    logic [7:0] rise, clr, nxt;
    rise = req_in & ~m_hist;
    clr  = '0;
    if (ack_valid) clr[ack_idx]  = ~m_trig[ack_idx];
    if (poll_clr)  clr[poll_idx] = clr[poll_idx] | ~m_trig[poll_idx];
    for (int i = 0; i < N; i++) begin
      if (init_clr)       nxt[i] = rise[i];
      else if (m_trig[i]) nxt[i] = req_in[i];
      else                nxt[i] = (m_pend[i] & ~clr[i]) | rise[i];
    end
    return nxt;
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // inputs already driven at a falling edge; advance one rising edge, compare
  task automatic step(input string tag);
    logic [7:0] np, nt, nh;
    if (rst) begin
      np = '0; nt = '0; nh = '0;
    end else begin
      np = next_pend();
      nh = req_in;
      if (init_clr)        nt = '0;
      else if (trig_wr_en) nt = trig_wr_data & MASK;
      else                 nt = m_trig;
    end
    @(posedge clk);
    m_pend = np; m_trig = nt; m_hist = nh;
    @(negedge clk);
    check({tag, " pend"}, pend_o, m_pend);
    check({tag, " trig"}, trig_o, m_trig);
  endtask

  task automatic idle();
    trig_wr_en = 0; ack_valid = 0; poll_clr = 0; init_clr = 0;
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    m_hist = '0; m_pend = '0; m_trig = '0;
    rst = 1; req_in = '0; trig_wr_data = '0; ack_idx = '0; poll_idx = '0;
    idle();
    @(negedge clk);
    step("R1 reset");
    step("R1 reset");
    rst = 0;

    // R7: masked write, lines 0..2 stay edge
    trig_wr_en = 1; trig_wr_data = 8'hFF;
    step("R7 masked write");
    check("R7 value", trig_o, 8'hF8);
    idle();
    step("R11 hold");

    // R3/R4/R5 on edge line 0
    req_in[0] = 1; step("R3 edge set");
    check("R3 bit0", pend_o[0], 1'b1);
    req_in[0] = 0; step("R4 fall keeps");
    check("R4 bit0", pend_o[0], 1'b1);
    ack_valid = 1; ack_idx = 3'd0; step("R5 ack edge");
    check("R5 bit0", pend_o[0], 1'b0);
    idle();

    // R2/R6 on level line 4
    req_in[4] = 1; step("R2 level high");
    check("R2 bit4", pend_o[4], 1'b1);
    ack_valid = 1; ack_idx = 3'd4; step("R6 ack level");
    check("R6 bit4", pend_o[4], 1'b1);
    idle();
    req_in[4] = 0; step("R2 level low");
    check("R2 bit4 low", pend_o[4], 1'b0);

    // R8 poll clear
    req_in[1] = 1; step("R8 setup");
    poll_clr = 1; poll_idx = 3'd1; step("R8 poll edge");
    check("R8 bit1", pend_o[1], 1'b0);
    idle();
    req_in[5] = 1; step("R8 setup level");
    poll_clr = 1; poll_idx = 3'd5; step("R8 poll level");
    check("R8 bit5", pend_o[5], 1'b1);
    idle(); req_in[5] = 0; req_in[1] = 0; step("R8 tidy");

    // R10 rising edge with ack of the same line
    req_in[2] = 1; step("R10 setup");
    req_in[2] = 0; step("R10 setup");
    req_in[2] = 1; ack_valid = 1; ack_idx = 3'd2; step("R10 ack vs edge");
    check("R10 bit2", pend_o[2], 1'b1);
    idle();

    // R9 init with line 2 held high
    init_clr = 1; step("R9 init");
    check("R9 pend", pend_o, 8'h00);
    check("R9 trig", trig_o, 8'h00);
    idle(); step("R9 no retrigger");
    check("R9 held", pend_o[2], 1'b0);

    // R10 init vs rising edge, init over write
    req_in[1] = 1; init_clr = 1; trig_wr_en = 1; trig_wr_data = 8'hFF;
    step("R10 init vs edge");
    check("R10 bit1", pend_o[1], 1'b1);
    check("R9 init beats write", trig_o, 8'h00);
    idle();

    // seeded random mix
    void'($urandom(32'd20240611));
    for (int k = 0; k < 3000; k++) begin
      req_in       = 8'($urandom);
      trig_wr_en   = ($urandom % 8) == 0;
      trig_wr_data = 8'($urandom);
      ack_valid    = ($urandom % 3) == 0;
      ack_idx      = 3'($urandom);
      poll_clr     = ($urandom % 5) == 0;
      poll_idx     = 3'($urandom);
      init_clr     = ($urandom % 40) == 0;
      step("R2 R3 R5 R8 random");
    end
    idle();
    rst = 1; step("R1 late reset");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule